// File: doc/BRIEF.md
# Bus Protection Step Controller

This block fences off the interconnect path of a power domain before the domain is switched off, and reopens that path after the domain is powered again. It works through a short, fixed list of protection steps. Each step names one bit position and one of two register banks (low or high). Protection for a step is raised with a one-cycle set strobe carrying a one-hot mask, and removed with a one-cycle clear strobe carrying the same mask. The enable register is never read back and rewritten.

A start pulse with a direction input launches a sequence. In the protect direction the steps run from index 0 upward, and each step waits for its ready-status bit before the next one starts. If that bit does not arrive within a bounded number of polls, the same step is undone, the sequence stops and an error is flagged. In the release direction the steps run from the last index down to 0, one per cycle, with no handshake. The step table, the poll spacing and the poll limit are parameters. All pins are plain control and status levels or pulses. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `bus_prot_seq`

## Requirements
- R1: A write is a one-cycle strobe on `wr_set` or on `wr_clr`, never both in the same cycle. The write carries in `wr_mask` exactly one bit, at the step's bit position.
- R2: When `protect`=1 at an accepted start, the block issues one set strobe per step, in index order 0, 1, … NUM_STEPS-1.
- R3: After each protect write, the next step is not written until the step's ready bit reads 1. When ready bits are already 1, each step takes two cycles, and `done` appears 2·NUM_STEPS+1 cycles after the start edge.
- R4: When `protect`=0 at an accepted start, the block issues clear strobes in index order NUM_STEPS-1 down to 0, one per cycle, and ignores the ready inputs. `done` appears NUM_STEPS+1 cycles after the start edge.
- R5: If a protect step fails, the block issues a clear strobe for that same step in the cycle after the last poll. It writes no later step, and it raises `err` in the `done` cycle.
- R6: Ready is polled POLL_LIMIT times, first in the cycle after the write and then every POLL_GAP cycles. The undo strobe therefore comes 2+(POLL_LIMIT-1)·POLL_GAP cycles after the failing set strobe.
- R7: Bit i of STEP_BANK selects the bank of step i (0 = low, 1 = high). `wr_bank` drives that value during the step's writes, and ready is read from `rdy_lo` or `rdy_hi` accordingly, never from the other bank.
- R8: `busy` is high from the cycle after an accepted start through the `done` cycle. A start while `busy` is high is ignored.
- R9: `done` is a one-cycle pulse. `err` holds its value after `done` until the next accepted start, which clears it.
- R10: After reset, `busy`, `done`, `err`, `wr_set` and `wr_clr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch request, accepted only while idle |
| protect | input | 1 | Direction at start: 1 protect, 0 release |
| rdy_lo | input | BANK_W | Ready status, low bank |
| rdy_hi | input | BANK_W | Ready status, high bank |
| wr_set | output | 1 | Write-one-to-set strobe |
| wr_clr | output | 1 | Write-one-to-clear strobe |
| wr_bank | output | 1 | Bank of the current write (0 low, 1 high) |
| wr_mask | output | BANK_W | One-hot mask of the current write |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Last sequence ended with an undone step |

## Verification
Two events can land in the same cycle: a new start request while a protect sequence is still polling, and that sequence's own progress. The bench pulses a release request in the middle of a slow protect run. It then checks that the strobe log holds only the protect writes, in order, and that `busy` stayed high. A second race is the ready bit rising close to a poll. The bench raises it between two polls and checks that the next set strobe comes only after the rise and that no undo follows.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WRITE  = 3'd1,
    ST_POLL   = 3'd2,
    ST_UNDO   = 3'd3,
    ST_FINISH = 3'd4
  } seq_state_t;
endpackage

// File: rtl/bps_step_lookup.sv
module bps_step_lookup #(
  parameter int NUM_STEPS = 3,
  parameter int BIT_IDX_W = 5,
  parameter int IDX_W     = 2,
  parameter logic [NUM_STEPS*BIT_IDX_W-1:0] STEP_BIT  = '0,
  parameter logic [NUM_STEPS-1:0]           STEP_BANK = '0
) (
  input  logic [IDX_W-1:0]     idx,
  output logic [BIT_IDX_W-1:0] bit_pos,
  output logic                 bank
);
  logic [BIT_IDX_W-1:0] bit_tab [NUM_STEPS];

  for (genvar g = 0; g < NUM_STEPS; g++) begin : g_tab
    assign bit_tab[g] = STEP_BIT[g*BIT_IDX_W +: BIT_IDX_W];
  end

  always_comb begin
    bit_pos = '0;
    bank    = 1'b0;
    for (int i = 0; i < NUM_STEPS; i++) begin
      if (idx == IDX_W'(i)) begin
        bit_pos = bit_tab[i];
        bank    = STEP_BANK[i];
      end
    end
  end
endmodule

// File: rtl/bps_poll_timer.sv
module bps_poll_timer #(
  parameter int POLL_GAP   = 1000,
  parameter int POLL_LIMIT = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic active,
  output logic check,
  output logic last
);
  localparam int GAP_W = $clog2(POLL_GAP + 1);
  localparam int CNT_W = $clog2(POLL_LIMIT + 1);

  logic [GAP_W-1:0] gap_q;
  logic [CNT_W-1:0] polls_q;

  assign check = active && (gap_q == '0);
  assign last  = (polls_q == CNT_W'(POLL_LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q   <= '0;
      polls_q <= '0;
    end else if (arm) begin
      gap_q   <= '0;
      polls_q <= '0;
    end else if (active) begin
      if (gap_q == '0) begin
        gap_q   <= GAP_W'(POLL_GAP - 1);
        polls_q <= polls_q + 1'b1;
      end else begin
        gap_q <= gap_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/bus_prot_seq.sv
module bus_prot_seq #(
  parameter int BANK_W     = 32,
  parameter int NUM_STEPS  = 3,
  parameter int POLL_GAP   = 1000,
  parameter int POLL_LIMIT = 10000,
  parameter logic [NUM_STEPS*$clog2(BANK_W)-1:0] STEP_BIT = {5'd10, 5'd13, 5'd6},
  parameter logic [NUM_STEPS-1:0] STEP_BANK = 3'b100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              protect,
  input  logic [BANK_W-1:0] rdy_lo,
  input  logic [BANK_W-1:0] rdy_hi,
  output logic              wr_set,
  output logic              wr_clr,
  output logic              wr_bank,
  output logic [BANK_W-1:0] wr_mask,
  output logic              busy,
  output logic              done,
  output logic              err
);
  import bps_pkg::*;

  localparam int BIT_IDX_W = $clog2(BANK_W);
  localparam int IDX_W     = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_STEPS - 1);

  seq_state_t       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             prot_q;
  logic             err_q;

  logic [BIT_IDX_W-1:0] step_bit;
  logic                 step_bank;
  logic                 poll_chk, poll_last, rdy_bit;

  bps_step_lookup #(
    .NUM_STEPS(NUM_STEPS), .BIT_IDX_W(BIT_IDX_W), .IDX_W(IDX_W),
    .STEP_BIT(STEP_BIT), .STEP_BANK(STEP_BANK)
  ) u_lookup (
    .idx(idx_q), .bit_pos(step_bit), .bank(step_bank)
  );

  bps_poll_timer #(.POLL_GAP(POLL_GAP), .POLL_LIMIT(POLL_LIMIT)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .arm(state_q == ST_WRITE),
    .active(state_q == ST_POLL),
    .check(poll_chk), .last(poll_last)
  );

  assign rdy_bit = step_bank ? rdy_hi[step_bit] : rdy_lo[step_bit];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      prot_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          prot_q  <= protect;
          idx_q   <= protect ? '0 : LAST_IDX;
          err_q   <= 1'b0;
          state_q <= ST_WRITE;
        end
        ST_WRITE: begin
          if (prot_q)            state_q <= ST_POLL;
          else if (idx_q == '0)  state_q <= ST_FINISH;
          else                   idx_q   <= idx_q - 1'b1;
        end
        ST_POLL: begin
          if (poll_chk && rdy_bit) begin
            if (idx_q == LAST_IDX) state_q <= ST_FINISH;
            else begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_WRITE;
            end
          end else if (poll_chk && poll_last) begin
            state_q <= ST_UNDO;
          end
        end
        ST_UNDO: begin
          err_q   <= 1'b1;
          state_q <= ST_FINISH;
        end
        ST_FINISH: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_set  = (state_q == ST_WRITE) && prot_q;
  assign wr_clr  = ((state_q == ST_WRITE) && !prot_q) || (state_q == ST_UNDO);
  assign wr_bank = step_bank;
  assign wr_mask = BANK_W'(1) << step_bit;
  assign busy    = (state_q != ST_IDLE);
  assign done    = (state_q == ST_FINISH);
  assign err     = err_q;
endmodule

// File: rtl/bps_checker.sv
module bps_checker #(
  parameter int BANK_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              wr_set,
  input logic              wr_clr,
  input logic [BANK_W-1:0] wr_mask
);
  assert_strobe_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_set && wr_clr));

  assert_mask_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set || wr_clr) |-> ($countones(wr_mask) == 1));

  assert_write_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_set || wr_clr) |-> busy);

  assert_start_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_at_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);

  assert_err_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(err));
endmodule

bind bus_prot_seq bps_checker #(.BANK_W(BANK_W)) u_bps_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err(err), .wr_set(wr_set), .wr_clr(wr_clr), .wr_mask(wr_mask)
);

// File: tb/tb_bus_prot_seq.sv
module tb_bus_prot_seq;
  localparam int BW = 32;
  localparam int NS = 3;
  localparam int GAP = 3;
  localparam int LIM = 5;
  localparam int B0 = 6, B1 = 13, B2 = 10;
  localparam logic [NS-1:0] BANKS = 3'b100;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, protect = 1'b0;
  logic [BW-1:0] rdy_lo = '0, rdy_hi = '0;
  logic wr_set, wr_clr, wr_bank, busy, done, err;
  logic [BW-1:0] wr_mask;

  always #10 clk = ~clk;

  bus_prot_seq #(
    .BANK_W(BW), .NUM_STEPS(NS), .POLL_GAP(GAP), .POLL_LIMIT(LIM),
    .STEP_BIT({5'd10, 5'd13, 5'd6}), .STEP_BANK(BANKS)
  ) dut (.*);

  int n_chk = 0, n_bad = 0, smp = 0, lc = 0, done_at = 0;
  int lk [16]; int lb [16]; int lbit [16]; int ls [16];

  function automatic int bit_of(logic [BW-1:0] m);
    for (int i = 0; i < BW; i++) if (m[i]) return i;
    return -1;
  endfunction

  function automatic int step_bit(int s);
    return (s == 0) ? B0 : (s == 1) ? B1 : B2;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    smp++;
    if ((wr_set || wr_clr) && lc < 16) begin
      lk[lc] = wr_set ? 1 : 0; lb[lc] = int'(wr_bank);
      lbit[lc] = bit_of(wr_mask); ls[lc] = smp;
      chk(!(wr_set && wr_clr) && $countones(wr_mask) == 1, "R1 single strobe one-hot", int'(wr_set) + int'(wr_clr), 1);
      lc++;
    end
  endtask

  task automatic launch(bit dir);
    lc = 0; smp = 0;
    start = 1'b1; protect = dir;
    tick();
    start = 1'b0;
  endtask

  task automatic wait_done(int lim);
    while (!done && smp < lim) tick();
    done_at = smp;
    chk(done, "R9 done seen", int'(done), 1);
  endtask

  task automatic exp_entry(int i, int kind, int s, string req);
    chk(lk[i] == kind, req, lk[i], kind);
    chk(lbit[i] == step_bit(s), req, lbit[i], step_bit(s));
    chk(lb[i] == int'(BANKS[s]), {req, " R7 bank"}, lb[i], int'(BANKS[s]));
  endtask

  task automatic t_reset();
    chk(!busy && !done && !err && !wr_set && !wr_clr, "R10 reset state",
        int'({busy, done, err, wr_set, wr_clr}), 0);
  endtask

  task automatic t_protect_fast();
    rdy_lo = '1; rdy_hi = '1;
    launch(1'b1);
    wait_done(100);
    chk(lc == NS, "R2 write count", lc, NS);
    for (int s = 0; s < NS; s++) exp_entry(s, 1, s, "R2 forward order");
    chk(done_at == 2*NS + 1, "R3 done timing", done_at, 2*NS + 1);
    chk(!err, "R5 no error", int'(err), 0);
    tick();
    chk(!done, "R9 done one cycle", int'(done), 0);
  endtask

  task automatic t_release();
    rdy_lo = '0; rdy_hi = '0;
    launch(1'b0);
    wait_done(100);
    chk(lc == NS, "R4 write count", lc, NS);
    for (int s = 0; s < NS; s++) exp_entry(s, 0, NS - 1 - s, "R4 reverse order");
    chk(done_at == NS + 1, "R4 no wait timing", done_at, NS + 1);
    chk(!err, "R4 no error", int'(err), 0);
    tick();
  endtask

  task automatic t_late_ready_and_ignored_start();
    rdy_lo = '1; rdy_hi = '1; rdy_lo[B1] = 1'b0;
    launch(1'b1);
    tick();
    chk(busy, "R8 busy while running", int'(busy), 1);
    start = 1'b1; protect = 1'b0;
    tick();
    start = 1'b0;
    while (smp < 6) tick();
    rdy_lo[B1] = 1'b1;
    wait_done(100);
    chk(lc == NS, "R8 ignored start leaves log", lc, NS);
    for (int s = 0; s < NS; s++) exp_entry(s, 1, s, "R8 protect only");
    chk(ls[2] > 6, "R3 waits for ready", ls[2], 7);
    chk(!err, "R3 late ready no error", int'(err), 0);
    tick();
  endtask

  task automatic t_timeout();
    rdy_lo = '1; rdy_hi = '1; rdy_lo[B1] = 1'b0;
    launch(1'b1);
    wait_done(200);
    chk(lc == 3, "R5 no later step", lc, 3);
    exp_entry(0, 1, 0, "R5 step0 set");
    exp_entry(1, 1, 1, "R5 step1 set");
    exp_entry(2, 0, 1, "R5 undo same step");
    chk(ls[2] - ls[1] == 2 + (LIM - 1)*GAP, "R6 timeout spacing", ls[2] - ls[1], 2 + (LIM - 1)*GAP);
    chk(err, "R5 err at done", int'(err), 1);
    tick(); tick(); tick();
    chk(err, "R9 err held", int'(err), 1);
  endtask

  task automatic t_bank_select();
    rdy_lo = '1; rdy_hi = '0;
    launch(1'b1);
    chk(!err, "R9 err cleared by start", int'(err), 0);
    wait_done(200);
    chk(lc == 4, "R7 high bank step times out", lc, 4);
    exp_entry(2, 1, 2, "R7 step2 set");
    exp_entry(3, 0, 2, "R7 step2 undo");
    chk(err, "R7 err", int'(err), 1);
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_protect_fast();
    t_release();
    t_late_ready_and_ignored_start();
    t_timeout();
    t_bank_select();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule